// File: doc/BRIEF.md
# Serial Infrared Pulse Encoder/Decoder

This block sits between a UART core and the infrared transceiver pins. On the transmit side it turns every zero bit of the UART's serial output into a short pulse, and sends nothing for a one. On the receive side it detects pulses from the photodiode and rebuilds a normal non-return-to-zero stream for the UART receiver. All timing comes from a 16x baud enable (`tick16`) that a baud generator outside the block supplies. The fixed-width option also uses the system clock.

A five-bit control word is written through a single write strobe. It can switch each direction between infrared processing and plain pass-through, set the pulse polarity of each direction on its own, and make transmit pulses either 3/16 of a bit or a fixed absolute width. A new control word is staged first. It becomes active only at the next bit boundary of the block's own 16-tick phase counter, so a pulse is never cut short and the pin never changes idle level in the middle of a bit. A path that is bypassed has its counters held cleared and gets no timing enables.

Top module: `sir_phy`

## Requirements
- R1: After reset the active control word is 0: `ir_tx_pin` follows `uart_txd` and `uart_rxd` follows `ir_rx_pin`, both combinationally.
- R2: Control bits are bit 0 transmit encoder on, bit 1 receive decoder on, bit 2 fixed transmit width, bit 3 transmit inverted, bit 4 receive inverted. A write only takes effect at the next bit boundary. A boundary is the clock edge with `tick16` high when the phase counter, which counts ticks from reset modulo 16, reads 15.
- R3: While the encoder is off, `ir_tx_pin` equals `uart_txd` whatever the other control bits hold.
- R4: While the encoder is on and idle, the pin sits at its inactive level (low with bit 3 = 0, high with bit 3 = 1). Switching the encoder on produces no pulse during the first bit period after the switch.
- R5: At each boundary where the encoder is on, the encoder samples `uart_txd`, taken through two flops. A zero starts exactly one pulse on the cycle after that boundary. A one starts no pulse.
- R6: With bit 2 = 0 the pulse lasts exactly 3 `tick16` periods.
- R7: With bit 2 = 1 the pulse lasts exactly ceil(FIX_NS x CLK_HZ / 10^9) clock cycles, which is 200 cycles at the defaults (1.6 us at 125 MHz).
- R8: Transmit polarity: bit 3 = 0 gives a high pulse, bit 3 = 1 gives a low pulse.
- R9: While the decoder is off, `uart_rxd` equals `ir_rx_pin`.
- R10: While the decoder is on, an active edge on the synchronised pin drives `uart_rxd` low 3 clocks later. The active edge is rising with bit 4 = 0 and falling with bit 4 = 1. `uart_rxd` stays low until 16 ticks have passed, and is high at all other times. An edge of the other direction has no effect.
- R11: An active edge during a low window restarts the 16-tick count.
- R12: The fixed-width setting (bit 2) does not change decoder behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 5 | Control word to stage |
| uart_txd | input | 1 | Serial output of the UART transmitter |
| uart_rxd | output | 1 | Serial input to the UART receiver |
| ir_tx_pin | output | 1 | Drive to the infrared emitter |
| ir_rx_pin | input | 1 | Signal from the infrared detector |

## Verification
The assertions check, on every cycle, the properties that hold locally. The active control word changes only at a bit boundary. A transmit pulse starts only on the cycle after a boundary at which a zero was sampled. A tick-timed pulse ends only on a tick. A receive low window opens only when the synchronised pin is at the active level. Only the bench scenarios can show the end-to-end behaviour: the measured pulse widths in both width modes, the idle level seen when the encoder is switched on, that opposite-direction edges are ignored, the restart of the window on a second pulse, and that the pass-through paths match their pins.

// File: rtl/sir_pkg.sv
package sir_pkg;

    localparam int CFG_W = 5;

    // Field order sets the bit positions of the control word (bit 0 = tx_on)
    typedef struct packed {
        logic rx_inv;   // bit 4
        logic tx_inv;   // bit 3
        logic fix_w;    // bit 2
        logic rx_on;    // bit 1
        logic tx_on;    // bit 0
    } sir_cfg_t;

endpackage

// File: rtl/sir_sync.sv
module sir_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES < 2) begin : g_bad_stages
            $error("sir_sync needs at least two stages");
        end
    endgenerate

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sir_cfg.sv
module sir_cfg
    import sir_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output sir_cfg_t         cfg_act,
    output logic             bit_edge
);
    localparam int PH_W = $clog2(OVERSAMPLE);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVERSAMPLE - 1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
        sir_cfg_t        staged;
        sir_cfg_t        active;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    assign bit_edge = tick && (s_q.phase == PH_LAST);

    always_comb begin
        s_d = s_q;
        if (tick) begin
            s_d.phase = bit_edge ? '0 : s_q.phase + 1'b1;
        end
        if (wr_en) begin
            s_d.staged = sir_cfg_t'(wr_data);
        end
        if (bit_edge) begin
            s_d.active = s_q.staged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase  <= '0;
            s_q.staged <= '0;
            s_q.active <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_act = s_q.active;

    // R2: the working control word moves only at a bit boundary
    p_cfg_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_edge |=> $stable(cfg_act));
endmodule

// File: rtl/sir_enc.sv
module sir_enc #(
    parameter int PULSE_TICKS = 3,
    parameter int FIX_CYC     = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic bit_edge,
    input  logic tx_on,
    input  logic fix_w,
    input  logic tx_bit,
    output logic pulse
);
    localparam int MAXW = (FIX_CYC > PULSE_TICKS) ? FIX_CYC : PULSE_TICKS;
    localparam int CW   = $clog2(MAXW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          by_clk;
    } enc_state_t;

    enc_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!tx_on) begin
            s_d.cnt    = '0;
            s_d.by_clk = 1'b0;
        end else if (bit_edge && !tx_bit) begin
            s_d.cnt    = fix_w ? CW'(FIX_CYC) : CW'(PULSE_TICKS);
            s_d.by_clk = fix_w;
        end else if ((s_q.cnt != '0) && (s_q.by_clk || tick)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt    <= '0;
            s_q.by_clk <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = (s_q.cnt != '0);

    // R5: a pulse opens only right after a boundary that sampled a zero
    p_pulse_after_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(bit_edge && !tx_bit && tx_on));

    // R6: a tick-timed pulse closes only on a tick (or when switched off)
    p_tick_paced_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pulse) && !$past(s_q.by_clk)) |-> $past(tick || !tx_on));
endmodule

// File: rtl/sir_dec.sv
module sir_dec #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rx_on,
    input  logic rx_inv,
    input  logic rx_s,
    output logic busy
);
    localparam int CW = $clog2(OVERSAMPLE + 1);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } dec_state_t;

    dec_state_t s_d, s_q;
    logic       hit;

    always_comb begin
        hit = rx_inv ? (s_q.prev && !rx_s) : (!s_q.prev && rx_s);
        s_d      = s_q;
        s_d.prev = rx_s;
        if (!rx_on) begin
            s_d.cnt = '0;
        end else if (hit) begin
            s_d.cnt = CW'(OVERSAMPLE);
        end else if (tick && (s_q.cnt != '0)) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev <= 1'b0;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.cnt != '0);

    // R10: a low window opens only while the pin sits at the active level
    p_window_on_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(rx_s) != $past(rx_inv)));
endmodule

// File: rtl/sir_phy.sv
module sir_phy
    import sir_pkg::*;
#(
    parameter int CLK_HZ      = 125_000_000,
    parameter int FIX_NS      = 1600,
    parameter int OVERSAMPLE  = 16,
    parameter int PULSE_TICKS = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick16,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             uart_txd,
    output logic             uart_rxd,
    output logic             ir_tx_pin,
    input  logic             ir_rx_pin
);
    localparam longint NS_PER_S = 64'd1_000_000_000;
    localparam longint FIX_PROD = longint'(FIX_NS) * longint'(CLK_HZ);
    localparam int     FIX_CYC  = int'((FIX_PROD + NS_PER_S - 1) / NS_PER_S);

    generate
        if (FIX_CYC < 1) begin : g_bad_fix
            $error("fixed pulse width rounds to zero clock cycles");
        end
        if (PULSE_TICKS < 1 || PULSE_TICKS >= OVERSAMPLE) begin : g_bad_ticks
            $error("tick pulse width must lie inside one bit");
        end
    endgenerate

    sir_cfg_t act;
    logic     bit_edge;
    logic     tx_s, rx_s;
    logic     pulse, busy;

    sir_cfg #(.OVERSAMPLE(OVERSAMPLE)) u_cfg (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .wr_en(cfg_we), .wr_data(cfg_wdata),
        .cfg_act(act), .bit_edge(bit_edge)
    );

    sir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_tx_sync (
        .clk(clk), .rst_n(rst_n), .d(uart_txd), .q(tx_s)
    );

    sir_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rx_sync (
        .clk(clk), .rst_n(rst_n), .d(ir_rx_pin), .q(rx_s)
    );

    sir_enc #(.PULSE_TICKS(PULSE_TICKS), .FIX_CYC(FIX_CYC)) u_enc (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .bit_edge(bit_edge),
        .tx_on(act.tx_on), .fix_w(act.fix_w), .tx_bit(tx_s), .pulse(pulse)
    );

    sir_dec #(.OVERSAMPLE(OVERSAMPLE)) u_dec (
        .clk(clk), .rst_n(rst_n), .tick(tick16),
        .rx_on(act.rx_on), .rx_inv(act.rx_inv), .rx_s(rx_s), .busy(busy)
    );

    assign ir_tx_pin = act.tx_on ? (pulse ^ act.tx_inv) : uart_txd;
    assign uart_rxd  = act.rx_on ? !busy : ir_rx_pin;
endmodule

// File: tb/sir_phy_tb.sv
`timescale 1ns/1ps
module sir_phy_tb;
    localparam int TDIV = 20;           // clocks per tick16
    localparam int BIT  = 16 * TDIV;    // clocks per bit
    localparam int WD   = 3 * TDIV;     // default pulse width in clocks
    localparam int WF   = 200;          // fixed width at 125 MHz

    logic clk = 1'b0;
    logic rst_n, tick16, cfg_we, uart_txd, ir_rx_pin;
    logic [4:0] cfg_wdata;
    wire  uart_rxd, ir_tx_pin;

    int n_chk = 0, n_fail = 0, tick_no = -1, cdiv = 0, seed_v;
    bit done = 0;
    logic [4:0] m_act, m_shadow;
    logic m_prev;

    sir_phy u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .uart_txd(uart_txd), .uart_rxd(uart_rxd),
        .ir_tx_pin(ir_tx_pin), .ir_rx_pin(ir_rx_pin)
    );

    initial forever #4 clk = ~clk;

    initial begin
        tick16 = 1'b0;
        wait (rst_n === 1'b1);
        forever begin
            @(posedge clk);
            if (cdiv == TDIV - 1) begin
                cdiv <= 0; tick16 <= 1'b1; tick_no <= tick_no + 1;
            end else begin
                cdiv <= cdiv + 1; tick16 <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_bnd();
        do @(negedge clk); while (!(tick16 && (tick_no % 16) == 15));
    endtask

    task automatic cfg_write(input logic [4:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    // One bit period, entered at the negedge of a boundary cycle
    task automatic tx_period(input logic nb, input bit do_wr, input logic [4:0] wv,
                             input string tag);
        bit emit; int width, cnt, first, rises, mism; logic was;
        emit  = m_act[0] && !m_prev;
        width = m_act[2] ? WF : WD;
        m_act = m_shadow;
        cnt = 0; first = -1; rises = 0; mism = 0; was = 1'b0;
        for (int i = 0; i < BIT; i++) begin
            @(negedge clk);
            if (m_act[0]) begin
                if (ir_tx_pin != m_act[3]) begin
                    cnt++;
                    if (first < 0) first = i;
                    if (!was) rises++;
                    was = 1'b1;
                end else was = 1'b0;
            end else if (ir_tx_pin !== uart_txd) mism++;
            if (i == 0) uart_txd = nb;
            if (do_wr && i == 100) begin cfg_we = 1'b1; cfg_wdata = wv; end
            if (do_wr && i == 101) begin cfg_we = 1'b0; m_shadow = wv; end
        end
        if (m_act[0]) begin
            chk(cnt == (emit ? width : 0), tag, cnt, emit ? width : 0);
            if (emit) chk(first == 0 && rises == 1, tag, first, 0);
        end else begin
            chk(mism == 0, {tag, " R3 bypass"}, mism, 0);
        end
        m_prev = nb;
    endtask

    task automatic rx_try(input logic von, input logic voff, input int plen, input int gap,
                          input int lo_min, input int lo_max, input string tag);
        int lows, first;
        lows = 0; first = -1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (i > 0 && uart_rxd == 1'b0) begin
                lows++;
                if (first < 0) first = i;
            end
            if (i == 0) ir_rx_pin = von;
            if (i == plen) ir_rx_pin = voff;
            if (gap > 0 && i == gap) ir_rx_pin = von;
            if (gap > 0 && i == gap + plen) ir_rx_pin = voff;
        end
        chk(lows >= lo_min && lows <= lo_max, tag, lows, lo_min);
        if (lo_max > 0) chk(first >= 2 && first <= 4, tag, first, 3);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        seed_v = $urandom(32'd20240611);
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; uart_txd = 1'b1; ir_rx_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk(ir_tx_pin == 1'b1, "R1 tx follows in reset", ir_tx_pin, 1);
        chk(uart_rxd == 1'b0, "R1 rx follows in reset", uart_rxd, 0);
        rst_n = 1'b1;
        @(negedge clk); uart_txd = 1'b0; ir_rx_pin = 1'b1; #1;
        chk(ir_tx_pin == 1'b0, "R1 tx bypass after reset", ir_tx_pin, 0);
        chk(uart_rxd == 1'b1, "R1 rx bypass after reset", uart_rxd, 1);

        // R3: other bits set, encoder still off
        cfg_write(5'b01100);
        wait_bnd(); @(negedge clk);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk); uart_txd = 1'($urandom); ir_rx_pin = 1'($urandom); #1;
            chk(ir_tx_pin == uart_txd, "R3 bypass with mode bits", ir_tx_pin, uart_txd);
            chk(uart_rxd == ir_rx_pin, "R9 rx bypass", uart_rxd, ir_rx_pin);
        end

        // Transmit path
        uart_txd = 1'b1; ir_rx_pin = 1'b0; m_prev = 1'b1;
        m_act = 5'b01100; m_shadow = 5'b01100;
        repeat (4) @(negedge clk);
        wait_bnd();
        tx_period(1'b0, 1, 5'b00001, "R2 staged write not yet active");
        tx_period(1'b0, 0, 5'b0,     "R4 enable gives idle low and no pulse");
        tx_period(1'b1, 0, 5'b0,     "R6 default width");
        tx_period(1'b0, 0, 5'b0,     "R5 one bit sends no pulse");
        tx_period(1'b0, 1, 5'b01001, "R5 zero pulse");
        tx_period(1'b1, 0, 5'b0,     "R8 inverted pulse");
        tx_period(1'b0, 1, 5'b00101, "R4 idle high inverted");
        tx_period(1'b1, 0, 5'b0,     "R5 width from old setting");
        tx_period(1'b0, 0, 5'b0,     "R5 one after fixed select");
        tx_period(1'b1, 0, 5'b0,     "R7 fixed width");
        for (int k = 0; k < 20; k++) begin
            logic [4:0] wv;
            wv = 5'($urandom);
            wv[0] = ($urandom % 4) != 0;
            tx_period(1'($urandom), ($urandom % 3) == 0, wv, "R5 random bits");
        end

        // Receive path, positive pulses
        cfg_write(5'b00010);
        uart_txd = 1'b1; ir_rx_pin = 1'b0;
        wait_bnd(); repeat (400) @(negedge clk);
        chk(uart_rxd == 1'b1, "R10 idle high", uart_rxd, 1);
        rx_try(1'b1, 1'b0, 20, 0, 301, 320, "R10 positive pulse");
        rx_try(1'b1, 1'b0, 20, 100, 401, 420, "R11 retrigger");
        rx_try(1'b1, 1'b1, 0, 0, 301, 320, "R10 step up triggers");
        rx_try(1'b0, 1'b0, 0, 0, 0, 0, "R10 falling edge ignored");
        rx_try(1'b1, 1'b0, 20, 0, 301, 320, "R10 after ignored edge");

        // R12: fixed width selected, decoder unchanged
        cfg_write(5'b00110);
        wait_bnd(); repeat (4) @(negedge clk);
        rx_try(1'b1, 1'b0, 30, 0, 301, 320, "R12 decoder with fixed mode");

        // Negative pulses
        cfg_write(5'b10110);
        ir_rx_pin = 1'b1;
        wait_bnd(); repeat (400) @(negedge clk);
        chk(uart_rxd == 1'b1, "R10 inverted idle high", uart_rxd, 1);
        rx_try(1'b0, 1'b1, 20, 0, 301, 320, "R10 negative pulse");
        for (int k = 0; k < 6; k++) begin
            int plen, gap;
            plen = 2 + ($urandom % 40);
            gap  = ($urandom % 2) ? plen + 20 + ($urandom % 150) : 0;
            rx_try(1'b0, 1'b1, plen, gap, gap + 301, gap + 320, "R11 random pulses");
        end

        // Back to decoder off
        cfg_write(5'b00000);
        wait_bnd(); @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); ir_rx_pin = 1'($urandom); #1;
            chk(uart_rxd == ir_rx_pin, "R9 bypass restored", uart_rxd, ir_rx_pin);
        end
        finish_run();
    end
endmodule